// File: doc/BRIEF.md
# Trap Target and Handler Vector Generator

This block takes one pending trap and decides where it goes. From the current trap depth, the privilege and RED status bits, the trap type and the two table base registers, it picks one of four destinations: privileged, hyperprivileged, RED, or the error condition. It also gives the trap type that will actually be recorded, which a watchdog redirection or a RED entry can replace. It then forms the handler fetch address and the two sequential addresses after it. A power-on request has priority over any trap. It always vectors through the fixed RED base and also presents the reset values of the control registers.

The decision is combinational. Its result is captured in one register stage, and a one-cycle `done` strobe marks the cycle after the request. Between requests the outputs hold their last values. Saving the pre-trap state and fetching from the vector belong to neighbouring blocks.

Top module: `trap_vector_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `done` is 0 and every data output is 0.
- R2: `done` is high in exactly the cycle after a cycle in which `trap_req` or `por_req` was sampled high. Otherwise `done` is low and the outputs keep their previous values.
- R3: A `por_req` wins over `trap_req`. It gives target RED (code 2), effective type 1 and handler address RED_BASE | 0x20.
- R4: If `por_req` is low and either `red_bit` is set or `cur_tl` equals MAX_TL-1, the target is RED (code 2) and the effective type is 5. The handler is RED_BASE ORed with ((type << 5) & 0xFF), which gives RED_BASE | 0xA0. The RED check comes before the error check.
- R5: If the R4 condition does not hold and `cur_tl` is MAX_TL or higher, the target is error (code 3). The effective type equals the input type, and `pc`, `npc` and `nnpc` are 0.
- R6: If `hpriv_bit` is 0 and `cur_tl` is above MAX_PTL, and neither R4 nor R5 applies, the target is hyperprivileged (code 1) with effective type 2. Without `hpriv_bit`, the next level is privileged whatever `priv_bit` is.
- R7: Apart from R3–R6, the target is hyperprivileged (code 1) when `hpriv_bit` is set or the trap type is 384 or more. Otherwise it is privileged (code 0). In both cases the effective type equals the input type.
- R8: The privileged handler is `tba` with bits 14:0 cleared. Bit 14 is set when the new trap level (`cur_tl`+1) is above 1. This is ORed with ((type << 5) & 0x3FFF).
- R9: The hyperprivileged handler is `htba` with bits 13:0 cleared, ORed with ((effective type << 5) & 0x3FFF).
- R10: For every target except error, `npc` = `pc` + 4 and `nnpc` = `pc` + 8.
- R11: On a power-on strobe the reset-value outputs load as follows. `init_tl` = MAX_TL and `init_gl` = MAX_GL. `init_pstate` = 0x014 (enable-FP bit 4 and privileged bit 2). `init_hpstate` = 0x024 (RED bit 5 and hyperprivileged bit 2; bit 10 and bit 0 clear). `init_tick_msb` = 1. A plain trap leaves these outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Pending trap, sampled each cycle |
| por_req | input | 1 | Power-on request, has priority |
| cur_tl | input | TL_W | Current trap level |
| priv_bit | input | 1 | Privileged-mode status bit |
| hpriv_bit | input | 1 | Hyperprivileged-mode status bit |
| red_bit | input | 1 | RED-state status bit |
| trap_type | input | 9 | Trap type of the pending trap |
| tba | input | VA_W | Privileged table base |
| htba | input | VA_W | Hyperprivileged table base |
| done | output | 1 | Result strobe, one cycle after the request |
| target | output | 2 | 0 privileged, 1 hyperprivileged, 2 RED, 3 error |
| eff_tt | output | 9 | Trap type actually taken |
| pc | output | VA_W | Handler address |
| npc | output | VA_W | Handler address + 4 |
| nnpc | output | VA_W | Handler address + 8 |
| init_tl | output | TL_W | Trap level reset value |
| init_gl | output | GL_W | Global level reset value |
| init_pstate | output | 13 | Processor state reset value |
| init_hpstate | output | 11 | Hypervisor state reset value |
| init_tick_msb | output | 1 | Tick register top bit reset value |

## Verification
The guest watchdog redirection is the hardest case to reach. It needs a trap depth strictly between MAX_PTL and MAX_TL-1, the hyperprivileged bit clear and no RED bit. Random trap levels hit that band only rarely, and a nearby level falls instead into the RED or error checks that take priority. The stimulus therefore sweeps every trap level from 0 to 7 against each combination of the three status bits, with trap types just below and at 384. A random phase with independent bases and types then follows, and each cycle is compared with a behavioural model.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
  localparam int TT_W    = 9;
  localparam int PST_W   = 13;
  localparam int HPST_W  = 11;
  localparam int INST_B  = 4;

  localparam logic [TT_W-1:0] TT_POWERON = 9'd1;
  localparam logic [TT_W-1:0] TT_WDOG    = 9'd2;
  localparam logic [TT_W-1:0] TT_REDX    = 9'd5;
  localparam logic [TT_W-1:0] TT_HYP_MIN = 9'd384;

  localparam logic [PST_W-1:0]  PST_RESET  = 13'h014;
  localparam logic [HPST_W-1:0] HPST_RESET = 11'h024;

  typedef enum logic [1:0] {
    TGT_PRIV = 2'd0,
    TGT_HYP  = 2'd1,
    TGT_RED  = 2'd2,
    TGT_ERR  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_PRIV = 2'd1,
    LVL_HYP  = 2'd2
  } lvl_e;
endpackage

// File: rtl/tvg_level_decode.sv
module tvg_level_decode
  import tvg_pkg::*;
(
  input  logic hpriv_bit,
  input  logic priv_bit,
  output lvl_e cur_lvl,
  output lvl_e next_lvl
);
  always_comb begin
    if (hpriv_bit)     cur_lvl = LVL_HYP;
    else if (priv_bit) cur_lvl = LVL_PRIV;
    else               cur_lvl = LVL_USER;
    next_lvl = (cur_lvl == LVL_USER) ? LVL_PRIV : cur_lvl;
  end
endmodule

// File: rtl/tvg_target_sel.sv
module tvg_target_sel
  import tvg_pkg::*;
#(
  parameter int TL_W    = 3,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2
) (
  input  logic            por,
  input  logic [TL_W-1:0] tl,
  input  logic            red_bit,
  input  lvl_e            next_lvl,
  input  logic [TT_W-1:0] tt_in,
  output tgt_e            tgt,
  output logic [TT_W-1:0] tt_out,
  output logic            deep_tl
);
  localparam logic [TL_W-1:0] TL_TOP  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_LAST = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_PLIM = TL_W'(MAX_PTL);

  always_comb begin
    tgt     = TGT_PRIV;
    tt_out  = tt_in;
    deep_tl = (tl != '0);
    if (por) begin
      tgt    = TGT_RED;
      tt_out = TT_POWERON;
    end else if (red_bit || tl == TL_LAST) begin
      tgt    = TGT_RED;
      tt_out = TT_REDX;
    end else if (tl >= TL_TOP) begin
      tgt    = TGT_ERR;
    end else if (tl > TL_PLIM && next_lvl == LVL_PRIV) begin
      tgt    = TGT_HYP;
      tt_out = TT_WDOG;
    end else if (next_lvl == LVL_HYP || tt_in >= TT_HYP_MIN) begin
      tgt    = TGT_HYP;
    end
  end
endmodule

// File: rtl/tvg_vector_calc.sv
module tvg_vector_calc
  import tvg_pkg::*;
#(
  parameter int          VA_W     = 64,
  parameter logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000
) (
  input  tgt_e            tgt,
  input  logic [TT_W-1:0] tt,
  input  logic [VA_W-1:0] tba,
  input  logic [VA_W-1:0] htba,
  input  logic            deep_tl,
  output logic [VA_W-1:0] pc,
  output logic [VA_W-1:0] npc,
  output logic [VA_W-1:0] nnpc
);
  localparam logic [VA_W-1:0] RED_VA = RED_BASE[VA_W-1:0];
  localparam logic [VA_W-1:0] STEP   = VA_W'(INST_B);

  logic [VA_W-1:0] off14, off8, red_va, hyp_va, prv_va;

  always_comb begin
    off14  = '0;
    off14[13:5] = tt;
    off8   = '0;
    off8[7:5] = tt[2:0];
    red_va = RED_VA | off8;
    hyp_va = {htba[VA_W-1:14], 14'd0} | off14;
    prv_va = {tba[VA_W-1:15], deep_tl, 14'd0} | off14;
    unique case (tgt)
      TGT_RED:  pc = red_va;
      TGT_HYP:  pc = hyp_va;
      TGT_PRIV: pc = prv_va;
      default:  pc = '0;
    endcase
    if (tgt == TGT_ERR) begin
      npc  = '0;
      nnpc = '0;
    end else begin
      npc  = pc + STEP;
      nnpc = pc + (STEP << 1);
    end
  end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import tvg_pkg::*;
#(
  parameter int          VA_W     = 64,
  parameter int          TL_W     = 3,
  parameter int          MAX_TL   = 6,
  parameter int          MAX_PTL  = 2,
  parameter int          GL_W     = 3,
  parameter int          MAX_GL   = 3,
  parameter logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req,
  input  logic              por_req,
  input  logic [TL_W-1:0]   cur_tl,
  input  logic              priv_bit,
  input  logic              hpriv_bit,
  input  logic              red_bit,
  input  logic [8:0]        trap_type,
  input  logic [VA_W-1:0]   tba,
  input  logic [VA_W-1:0]   htba,
  output logic              done,
  output logic [1:0]        target,
  output logic [8:0]        eff_tt,
  output logic [VA_W-1:0]   pc,
  output logic [VA_W-1:0]   npc,
  output logic [VA_W-1:0]   nnpc,
  output logic [TL_W-1:0]   init_tl,
  output logic [GL_W-1:0]   init_gl,
  output logic [12:0]       init_pstate,
  output logic [10:0]       init_hpstate,
  output logic              init_tick_msb
);
  lvl_e            cur_lvl, next_lvl;
  tgt_e            sel_tgt;
  logic [TT_W-1:0] sel_tt;
  logic            deep_tl;
  logic [VA_W-1:0] v_pc, v_npc, v_nnpc;
  logic            fire;

  assign fire = trap_req | por_req;

  tvg_level_decode u_lvl (
    .hpriv_bit (hpriv_bit),
    .priv_bit  (priv_bit),
    .cur_lvl   (cur_lvl),
    .next_lvl  (next_lvl)
  );

  tvg_target_sel #(.TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)) u_sel (
    .por      (por_req),
    .tl       (cur_tl),
    .red_bit  (red_bit),
    .next_lvl (next_lvl),
    .tt_in    (trap_type),
    .tgt      (sel_tgt),
    .tt_out   (sel_tt),
    .deep_tl  (deep_tl)
  );

  tvg_vector_calc #(.VA_W(VA_W), .RED_BASE(RED_BASE)) u_vec (
    .tgt     (sel_tgt),
    .tt      (sel_tt),
    .tba     (tba),
    .htba    (htba),
    .deep_tl (deep_tl),
    .pc      (v_pc),
    .npc     (v_npc),
    .nnpc    (v_nnpc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      target <= 2'd0;
      eff_tt <= '0;
      pc     <= '0;
      npc    <= '0;
      nnpc   <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        target <= sel_tgt;
        eff_tt <= sel_tt;
        pc     <= v_pc;
        npc    <= v_npc;
        nnpc   <= v_nnpc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_tl       <= '0;
      init_gl       <= '0;
      init_pstate   <= '0;
      init_hpstate  <= '0;
      init_tick_msb <= 1'b0;
    end else if (por_req) begin
      init_tl       <= TL_W'(MAX_TL);
      init_gl       <= GL_W'(MAX_GL);
      init_pstate   <= PST_RESET;
      init_hpstate  <= HPST_RESET;
      init_tick_msb <= 1'b1;
    end
  end
endmodule

// File: rtl/tvg_checker.sv
module tvg_checker #(
  parameter int VA_W    = 64,
  parameter int TL_W    = 3,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_req,
  input logic            por_req,
  input logic [TL_W-1:0] cur_tl,
  input logic            hpriv_bit,
  input logic            red_bit,
  input logic [VA_W-1:0] tba,
  input logic [VA_W-1:0] htba,
  input logic            done,
  input logic [1:0]      target,
  input logic [8:0]      eff_tt,
  input logic [VA_W-1:0] pc,
  input logic [VA_W-1:0] npc,
  input logic [VA_W-1:0] nnpc
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst || !armed)
    done |-> $past(trap_req || por_req)); // R2

  AST_POR_RED: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(por_req) |-> (done && target == 2'd2 && eff_tt == 9'd1)); // R3

  AST_RED_TYPE: assert property (@(posedge clk) disable iff (rst || !armed)
    (done && target == 2'd2) |-> (eff_tt == 9'd1 || eff_tt == 9'd5)); // R4

  AST_ERR_AT_MAX: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(trap_req && !por_req && !red_bit && cur_tl >= TL_W'(MAX_TL)) |-> target == 2'd3); // R5

  AST_GUEST_WDOG: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(trap_req && !por_req && !red_bit && !hpriv_bit &&
          cur_tl > TL_W'(MAX_PTL) && cur_tl < TL_W'(MAX_TL - 1))
    |-> (target == 2'd1 && eff_tt == 9'd2)); // R6

  AST_PRIV_BASE: assert property (@(posedge clk) disable iff (rst || !armed)
    (done && target == 2'd0) |-> pc[VA_W-1:15] == $past(tba[VA_W-1:15])); // R8

  AST_HYP_BASE: assert property (@(posedge clk) disable iff (rst || !armed)
    (done && target == 2'd1) |-> pc[VA_W-1:14] == $past(htba[VA_W-1:14])); // R9

  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (rst || !armed)
    (done && target != 2'd3) |-> (npc == pc + VA_W'(4) && nnpc == npc + VA_W'(4))); // R10
endmodule

bind trap_vector_gen tvg_checker #(
  .VA_W(VA_W), .TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
) u_chk (
  .clk(clk), .rst(rst), .trap_req(trap_req), .por_req(por_req),
  .cur_tl(cur_tl), .hpriv_bit(hpriv_bit), .red_bit(red_bit),
  .tba(tba), .htba(htba), .done(done), .target(target),
  .eff_tt(eff_tt), .pc(pc), .npc(npc), .nnpc(nnpc)
);

// File: tb/sim_trap_vector_gen.sv
`timescale 1ns/1ps
module sim_trap_vector_gen;
  localparam int VA_W = 64;
  localparam int TL_W = 3;
  localparam int MAXT = 6;
  localparam int MAXP = 2;
  localparam int MAXG = 3;
  localparam logic [63:0] REDB = 64'h0000_00FF_F000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_req = 0, por_req = 0, priv_bit = 0, hpriv_bit = 0, red_bit = 0;
  logic [TL_W-1:0] cur_tl = '0;
  logic [8:0] trap_type = '0;
  logic [VA_W-1:0] tba = '0, htba = '0;
  logic done, init_tick_msb;
  logic [1:0] target;
  logic [8:0] eff_tt;
  logic [VA_W-1:0] pc, npc, nnpc;
  logic [TL_W-1:0] init_tl;
  logic [2:0] init_gl;
  logic [12:0] init_pstate;
  logic [10:0] init_hpstate;

  always #2.5 clk = ~clk;

  trap_vector_gen u0 (.*);

  int checks = 0, errors = 0;
  logic e_done = 0, e_tick = 0;
  logic [1:0] e_tgt = 0;
  logic [8:0] e_tt = 0;
  logic [63:0] e_pc = 0, e_npc = 0, e_nnpc = 0;
  logic [63:0] e_init = 0;
  string tag = "R1";

  task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2", "done", 64'(done), 64'(e_done));
    chk(tag, "target", 64'(target), 64'(e_tgt));
    chk(tag, "eff_tt", 64'(eff_tt), 64'(e_tt));
    chk(tag, "pc", pc, e_pc);
    chk("R10", "npc", npc, e_npc);
    chk("R10", "nnpc", nnpc, e_nnpc);
    chk("R11", "init", {init_tl, init_gl, init_pstate, init_hpstate, init_tick_msb},
        e_init[TL_W+3+13+11:0]);
  endtask

  // behavioural reference: computes expectations for the inputs being driven
  task automatic model();
    int lvl, nxt, t;
    logic [63:0] off;
    e_done = trap_req | por_req;
    if (!e_done) begin tag = "R2"; return; end
    t = int'(trap_type);
    if (por_req) begin
      e_tgt = 2; e_tt = 1; e_pc = REDB | 64'h20; tag = "R3";
      e_init = {59'd0, 3'(MAXT), 3'(MAXG), 13'h014, 11'h024, 1'b1} ;
    end else if (red_bit || int'(cur_tl) == MAXT - 1) begin
      e_tgt = 2; e_tt = 5; e_pc = REDB | ((64'd5 * 32) & 64'hFF); tag = "R4";
    end else if (int'(cur_tl) >= MAXT) begin
      e_tgt = 3; e_tt = trap_type; e_pc = 0; tag = "R5";
    end else begin
      lvl = hpriv_bit ? 2 : (priv_bit ? 1 : 0);
      nxt = (lvl == 0) ? 1 : lvl;
      if (int'(cur_tl) > MAXP && nxt == 1) begin
        e_tgt = 1; e_tt = 2; tag = "R6";
      end else if (nxt == 2 || t >= 384) begin
        e_tgt = 1; e_tt = trap_type; tag = "R7";
      end else begin
        e_tgt = 0; e_tt = trap_type; tag = "R8";
      end
      off = (64'(e_tt) * 32) % 64'd16384;
      if (e_tgt == 1) e_pc = (htba & ~64'h3FFF) | off;
      else e_pc = (tba & ~64'h7FFF) | ((int'(cur_tl) + 1 > 1) ? 64'h4000 : 64'h0) | off;
      if (tag == "R7" && e_tgt == 1) tag = "R9";
    end
    if (e_tgt == 3) begin e_npc = 0; e_nnpc = 0; end
    else begin e_npc = e_pc + 4; e_nnpc = e_pc + 8; end
  endtask

  task automatic step(input logic p, input logic r, input int tl, input logic pv,
                      input logic hp, input logic rd, input int tt,
                      input logic [63:0] b, input logic [63:0] hb);
    por_req = p; trap_req = r; cur_tl = TL_W'(tl); priv_bit = pv; hpriv_bit = hp;
    red_bit = rd; trap_type = 9'(tt); tba = b; htba = hb;
    model();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "done", 64'(done), 0);
    chk("R1", "pc", pc, 0);
    chk("R1", "init", 64'(init_pstate), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "post-reset pc", pc, 0);
    tag = "R1";
    // R3 power-on wins over a trap
    step(1, 1, 0, 0, 0, 0, 9'h30, 64'h1234_8000, 64'h5678_4000);
    // R11: a plain trap leaves init values held
    step(0, 1, 0, 1, 0, 0, 9'h10, 64'hAAAA_0000_0001_8000, 64'h0);
    // R2: idle cycle holds outputs
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: RED via bit and via TL = MAX-1 (RED before error)
    step(0, 1, 1, 1, 0, 1, 9'h44, 64'h8000, 64'h4000);
    step(0, 1, MAXT - 1, 0, 1, 0, 9'h44, 64'h8000, 64'h4000);
    step(0, 1, MAXT, 0, 0, 1, 9'h44, 64'h8000, 64'h4000);
    // R5: error at and above max
    step(0, 1, MAXT, 1, 0, 0, 9'h1AB, 64'h8000, 64'h4000);
    step(0, 1, 7, 0, 1, 0, 9'h011, 64'h8000, 64'h4000);
    // R6: guest watchdog band, user and priv
    step(0, 1, MAXP + 1, 0, 0, 0, 9'h24, 64'hFFFF_8000, 64'hCAFE_C000);
    step(0, 1, MAXP + 2, 1, 0, 0, 9'h180, 64'hFFFF_8000, 64'hCAFE_FFFF);
    // R7/R9: hyper from hpriv and from type >= 384
    step(0, 1, 1, 0, 1, 0, 9'h7C, 64'h0, 64'hDEAD_BEEF_FFFF);
    step(0, 1, 0, 1, 0, 0, 384, 64'h0, 64'h1_2345_6789);
    // R8: type 383 stays privileged; TL 0 vs TL 1 bit 14
    step(0, 1, 0, 0, 0, 0, 383, 64'h7654_3210_FFFF, 0);
    step(0, 1, 1, 0, 0, 0, 383, 64'h7654_3210_FFFF, 0);
    step(0, 1, MAXP, 1, 0, 0, 9'h1FF, 64'h7654_3210_FFFF, 0);
    // sweep: every TL x status bits x boundary types
    for (int tl = 0; tl < 8; tl++)
      for (int sb = 0; sb < 8; sb++)
        for (int k = 0; k < 2; k++)
          step(0, 1, tl, sb[0], sb[1], sb[2], k ? 384 : 383,
               64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    // random phase
    for (int i = 0; i < 400; i++)
      step(($urandom % 23) == 0, ($urandom % 4) != 0, int'($urandom % 8),
           1'($urandom), 1'(($urandom % 3) == 0), 1'(($urandom % 6) == 0),
           int'($urandom % 512), {$urandom, $urandom}, {$urandom, $urandom});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule